// File: doc/BRIEF.md
# Egress Queue Priority Scheduler with Deficit Round Robin

This block decides which of the egress queues of one channel may send its next packet. Every queue is placed on one of five service levels. The lower three levels are guaranteed service and the upper two are excess service. A strictly lower level number always wins. Queues that share the winning level are served by a deficit round robin. Each queue's deficit counter gains its quantum once per round, and a queue is served only when its head packet fits inside the counter.

Each queue has two token buckets, one for its committed rate and one for its excess rate. While the committed bucket covers the head packet, the queue competes on its configured guaranteed level. When only the excess bucket covers it, the queue drops to an excess level. When neither bucket covers it, the queue does not compete. The strict-high level has an optional shared rate cap. When the cap cannot cover a packet, queues on that level are handled as if their committed bucket were empty, so lower queues still get service.

The scheduler presents one grant: the queue index and the level it won on. The level is meant for a parent scheduler. The grant stays until it is accepted, and the queue's buckets and deficit are charged at that point.

Top module: `egress_pdrr_sched`

## Requirements
- R1: While reset is applied, and in the cycles that follow its release, `grant_valid` is 0.
- R2: A grant always goes to a queue on the lowest-numbered level that any eligible queue holds. The levels are 0 strict-high, 1 guaranteed-high, 2 guaranteed-medium, 3 excess-high and 4 excess-low.
- R3: A non-empty queue whose committed tokens are at least its head length competes on its configured level (`q_prio` field: 0, 1, or 2/3 meaning 2). If not, but its excess tokens cover the length, it competes on level 3 (configured 0 or 1) or level 4 (configured 2 or 3). Otherwise it is never granted.
- R4: When `shcap_en` is 1 and the shared cap bucket holds fewer tokens than a strict-high queue's head length, that queue is handled as if its committed tokens were short, as in R3.
- R5: A queue is granted only if its head length is no larger than its deficit counter. When no queue on the winning level fits, every eligible queue on that level gains its quantum, saturating, and no grant is made in that cycle.
- R6: A queue's deficit counter is zero in the cycle after any cycle in which the queue is empty.
- R7: Each level keeps a round-robin pointer. The search starts at the pointer, and after a grant on a level is accepted, that level's pointer moves to the queue after the granted one.
- R8: A grant holds its queue and level unchanged until `grant_accept` is seen. It drops in the following cycle, so each accept consumes exactly one grant.
- R9: Buckets start empty after reset. Every `TICK_CYC` cycles each bucket gains its increment, saturating at its burst size. An accepted grant charges the head length to the committed bucket (levels 0-2) or to the excess bucket (levels 3-4), and also to the cap bucket when the level is 0 and the cap is enabled.
- R10: `grant_lvl` reports the level on which the granted queue won.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_nonempty | input | NQ | Per-queue has-a-packet flag |
| q_len | input | NQ*LEN_W | Per-queue head packet length |
| q_prio | input | NQ*2 | Per-queue configured guaranteed level |
| q_quantum | input | NQ*DEF_W | Per-queue deficit quantum per round |
| q_cir_inc | input | NQ*TOK_W | Committed bucket increment per tick |
| q_cir_burst | input | NQ*TOK_W | Committed bucket ceiling |
| q_eir_inc | input | NQ*TOK_W | Excess bucket increment per tick |
| q_eir_burst | input | NQ*TOK_W | Excess bucket ceiling |
| shcap_en | input | 1 | Enable of the strict-high rate cap |
| shcap_inc | input | TOK_W | Cap bucket increment per tick |
| shcap_burst | input | TOK_W | Cap bucket ceiling |
| grant_accept | input | 1 | Consumer takes the current grant |
| grant_valid | output | 1 | A grant is presented |
| grant_q | output | $clog2(NQ) | Granted queue index |
| grant_lvl | output | 3 | Level the granted queue won on |

## Verification
The bench targets the following corner cases.
- A long packet must wait through several deficit rounds while a short one is served. A scheduler that ignored the deficit would serve the long packet on its first turn.
- A queue goes empty and returns with a packet that its stale deficit would cover. A design that does not clear the counter would grant it ahead of its peer.
- Queues lose committed tokens, lose both kinds of tokens, and hit the strict-high cap. Wrong demotion shows up as the wrong winner or the wrong reported level.
- A bucket is left to fill for many ticks. A missing ceiling would let a burst of grants through.
- A grant is held without an accept. A design that re-picks, or that issues more than one grant per accept, would fail these checks.

// File: rtl/pdrr_pkg.sv
package pdrr_pkg;

  localparam int unsigned NUM_LVL = 5;

  typedef enum logic [2:0] {
    LVL_SH   = 3'd0,
    LVL_GH   = 3'd1,
    LVL_GM   = 3'd2,
    LVL_EH   = 3'd3,
    LVL_EL   = 3'd4,
    LVL_NONE = 3'd7
  } lvl_e;

  function automatic lvl_e guar_level(input logic [1:0] cfg);
    case (cfg)
      2'd0:    return LVL_SH;
      2'd1:    return LVL_GH;
      default: return LVL_GM;
    endcase
  endfunction

  function automatic lvl_e excess_level(input logic [1:0] cfg);
    return (cfg >= 2'd2) ? LVL_EL : LVL_EH;
  endfunction

endpackage

// File: rtl/tok_bucket.sv
module tok_bucket #(
  parameter int TOK_W = 20,
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [TOK_W-1:0] inc,
  input  logic [TOK_W-1:0] burst,
  input  logic             chg_en,
  input  logic [LEN_W-1:0] chg_amt,
  output logic [TOK_W-1:0] tokens
);

  logic [TOK_W-1:0] tok_q, tok_n, after_chg;
  logic [TOK_W:0]   sum;

  always_comb begin
    after_chg = tok_q;
    if (chg_en) begin
      after_chg = (tok_q >= TOK_W'(chg_amt)) ? tok_q - TOK_W'(chg_amt) : '0;
    end
    sum   = {1'b0, after_chg} + {1'b0, inc};
    tok_n = after_chg;
    if (tick) begin
      tok_n = (sum > {1'b0, burst}) ? burst : sum[TOK_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tok_q <= '0;
    else        tok_q <= tok_n;
  end

  assign tokens = tok_q;

endmodule

// File: rtl/q_classify.sv
module q_classify
  import pdrr_pkg::*;
#(
  parameter int TOK_W = 20,
  parameter int LEN_W = 14
) (
  input  logic             nonempty,
  input  logic [1:0]       prio_cfg,
  input  logic [LEN_W-1:0] len,
  input  logic [TOK_W-1:0] cir_tok,
  input  logic [TOK_W-1:0] eir_tok,
  input  logic             cap_en,
  input  logic [TOK_W-1:0] cap_tok,
  output lvl_e             lvl
);

  logic cir_ok, eir_ok, cap_ok, commit_ok;
  lvl_e g_lvl;

  always_comb begin
    g_lvl     = guar_level(prio_cfg);
    cir_ok    = cir_tok >= TOK_W'(len);
    eir_ok    = eir_tok >= TOK_W'(len);
    cap_ok    = !cap_en || (cap_tok >= TOK_W'(len));
    commit_ok = cir_ok && ((g_lvl != LVL_SH) || cap_ok);
    if (!nonempty)     lvl = LVL_NONE;
    else if (commit_ok) lvl = g_lvl;
    else if (eir_ok)   lvl = excess_level(prio_cfg);
    else               lvl = LVL_NONE;
  end

endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          found,
  output logic [IW-1:0] idx
);

  logic [IW:0] pos;

  always_comb begin
    found = 1'b0;
    idx   = ptr;
    pos   = '0;
    for (int k = 0; k < N; k++) begin
      pos = {1'b0, ptr} + (IW+1)'(k);
      if (pos >= (IW+1)'(N)) pos = pos - (IW+1)'(N);
      if (!found && req[pos[IW-1:0]]) begin
        found = 1'b1;
        idx   = pos[IW-1:0];
      end
    end
  end

endmodule

// File: rtl/egress_pdrr_sched.sv
module egress_pdrr_sched
  import pdrr_pkg::*;
#(
  parameter int NQ       = 8,
  parameter int LEN_W    = 14,
  parameter int TOK_W    = 20,
  parameter int DEF_W    = 16,
  parameter int TICK_CYC = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NQ-1:0]            q_nonempty,
  input  logic [NQ*LEN_W-1:0]      q_len,
  input  logic [NQ*2-1:0]          q_prio,
  input  logic [NQ*DEF_W-1:0]      q_quantum,
  input  logic [NQ*TOK_W-1:0]      q_cir_inc,
  input  logic [NQ*TOK_W-1:0]      q_cir_burst,
  input  logic [NQ*TOK_W-1:0]      q_eir_inc,
  input  logic [NQ*TOK_W-1:0]      q_eir_burst,
  input  logic                     shcap_en,
  input  logic [TOK_W-1:0]         shcap_inc,
  input  logic [TOK_W-1:0]         shcap_burst,
  input  logic                     grant_accept,
  output logic                     grant_valid,
  output logic [$clog2(NQ)-1:0]    grant_q,
  output logic [2:0]               grant_lvl
);

  localparam int QW  = $clog2(NQ);
  localparam int TCW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam int CW  = (LEN_W > DEF_W) ? LEN_W : DEF_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  // refill interval
  logic [TCW-1:0] tcnt_q, tcnt_n;
  logic           tick;
  assign tick = (tcnt_q == TCW'(TICK_CYC - 1));
  always_comb tcnt_n = tick ? '0 : tcnt_q + 1'b1;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) tcnt_q <= '0;
    else         tcnt_q <= tcnt_n;
  end

  // grant and scheduling state
  logic             gv_q, gv_n;
  logic [QW-1:0]    gq_q, gq_n;
  logic [2:0]       gl_q, gl_n;
  logic [LEN_W-1:0] glen_q, glen_n;
  logic [QW-1:0]    ptr_q [NUM_LVL];
  logic [QW-1:0]    ptr_n [NUM_LVL];
  logic [DEF_W-1:0] def_q [NQ];
  logic [DEF_W-1:0] def_n [NQ];
  logic             acc;

  assign acc = gv_q && grant_accept;

  // per-queue unpacking, buckets, classification
  logic [LEN_W-1:0] len_a   [NQ];
  logic [DEF_W-1:0] quant_a [NQ];
  logic [TOK_W-1:0] cir_tok [NQ];
  logic [TOK_W-1:0] eir_tok [NQ];
  logic [TOK_W-1:0] cap_tok;
  lvl_e             qlvl    [NQ];
  logic [NQ-1:0]    cir_chg, eir_chg;
  logic             cap_chg;
  logic [NQ*DEF_W-1:0] def_flat;

  assign cap_chg = acc && (gl_q == 3'(LVL_SH)) && shcap_en;

  tok_bucket #(.TOK_W(TOK_W), .LEN_W(LEN_W)) u_cap_bucket (
    .clk(clk), .rst_n(rst_sn), .tick(tick), .inc(shcap_inc),
    .burst(shcap_burst), .chg_en(cap_chg), .chg_amt(glen_q), .tokens(cap_tok)
  );

  for (genvar i = 0; i < NQ; i++) begin : g_q
    assign len_a[i]   = q_len[i*LEN_W +: LEN_W];
    assign quant_a[i] = q_quantum[i*DEF_W +: DEF_W];
    assign cir_chg[i] = acc && (gq_q == QW'(i)) && (gl_q <= 3'(LVL_GM));
    assign eir_chg[i] = acc && (gq_q == QW'(i)) && (gl_q >= 3'(LVL_EH));
    assign def_flat[i*DEF_W +: DEF_W] = def_q[i];

    tok_bucket #(.TOK_W(TOK_W), .LEN_W(LEN_W)) u_cir (
      .clk(clk), .rst_n(rst_sn), .tick(tick),
      .inc(q_cir_inc[i*TOK_W +: TOK_W]), .burst(q_cir_burst[i*TOK_W +: TOK_W]),
      .chg_en(cir_chg[i]), .chg_amt(glen_q), .tokens(cir_tok[i])
    );

    tok_bucket #(.TOK_W(TOK_W), .LEN_W(LEN_W)) u_eir (
      .clk(clk), .rst_n(rst_sn), .tick(tick),
      .inc(q_eir_inc[i*TOK_W +: TOK_W]), .burst(q_eir_burst[i*TOK_W +: TOK_W]),
      .chg_en(eir_chg[i]), .chg_amt(glen_q), .tokens(eir_tok[i])
    );

    q_classify #(.TOK_W(TOK_W), .LEN_W(LEN_W)) u_cls (
      .nonempty(q_nonempty[i]), .prio_cfg(q_prio[i*2 +: 2]), .len(len_a[i]),
      .cir_tok(cir_tok[i]), .eir_tok(eir_tok[i]), .cap_en(shcap_en),
      .cap_tok(cap_tok), .lvl(qlvl[i])
    );
  end

  // winning level and candidates on it
  logic [2:0]    best_lvl;
  logic [NQ-1:0] lvl_mask, fit_mask;
  logic [QW-1:0] sel_ptr, pick_idx;
  logic          pick_found, do_fill;

  always_comb begin
    best_lvl = 3'(LVL_NONE);
    for (int i = 0; i < NQ; i++) begin
      if (3'(qlvl[i]) < best_lvl) best_lvl = 3'(qlvl[i]);
    end
    for (int i = 0; i < NQ; i++) begin
      lvl_mask[i] = (best_lvl != 3'(LVL_NONE)) && (3'(qlvl[i]) == best_lvl);
      fit_mask[i] = lvl_mask[i] && (CW'(len_a[i]) <= CW'(def_q[i]));
    end
    sel_ptr = (best_lvl < 3'(NUM_LVL)) ? ptr_q[best_lvl] : '0;
  end

  rr_pick #(.N(NQ), .IW(QW)) u_pick (
    .req(fit_mask), .ptr(sel_ptr), .found(pick_found), .idx(pick_idx)
  );

  assign do_fill = !gv_q && (|lvl_mask) && !pick_found;

  // next state
  logic [DEF_W:0] dsum;
  always_comb begin
    gv_n   = gv_q;
    gq_n   = gq_q;
    gl_n   = gl_q;
    glen_n = glen_q;
    for (int l = 0; l < NUM_LVL; l++) ptr_n[l] = ptr_q[l];
    if (acc) begin
      gv_n = 1'b0;
      ptr_n[gl_q] = (gq_q == QW'(NQ - 1)) ? '0 : gq_q + 1'b1;
    end else if (!gv_q && pick_found) begin
      gv_n   = 1'b1;
      gq_n   = pick_idx;
      gl_n   = best_lvl;
      glen_n = len_a[pick_idx];
    end
    dsum = '0;
    for (int i = 0; i < NQ; i++) begin
      def_n[i] = def_q[i];
      if (acc && (gq_q == QW'(i))) begin
        def_n[i] = (CW'(def_q[i]) >= CW'(glen_q)) ? def_q[i] - DEF_W'(glen_q) : '0;
      end
      if (do_fill && lvl_mask[i]) begin
        dsum     = {1'b0, def_q[i]} + {1'b0, quant_a[i]};
        def_n[i] = dsum[DEF_W] ? '1 : dsum[DEF_W-1:0];
      end
      if (!q_nonempty[i]) def_n[i] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      gv_q   <= 1'b0;
      gq_q   <= '0;
      gl_q   <= 3'(LVL_NONE);
      glen_q <= '0;
      for (int l = 0; l < NUM_LVL; l++) ptr_q[l] <= '0;
      for (int i = 0; i < NQ; i++) def_q[i] <= '0;
    end else begin
      gv_q   <= gv_n;
      gq_q   <= gq_n;
      gl_q   <= gl_n;
      glen_q <= glen_n;
      for (int l = 0; l < NUM_LVL; l++) ptr_q[l] <= ptr_n[l];
      for (int i = 0; i < NQ; i++) def_q[i] <= def_n[i];
    end
  end

  assign grant_valid = gv_q;
  assign grant_q     = gq_q;
  assign grant_lvl   = gl_q;

endmodule

// File: rtl/egress_pdrr_sched_chk.sv
module egress_pdrr_sched_chk #(
  parameter int NQ    = 8,
  parameter int LEN_W = 14,
  parameter int TOK_W = 20,
  parameter int DEF_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  grant_valid,
  input logic                  grant_accept,
  input logic [$clog2(NQ)-1:0] grant_q,
  input logic [2:0]            grant_lvl,
  input logic [NQ-1:0]         q_nonempty,
  input logic [NQ*DEF_W-1:0]   def_flat,
  input logic [LEN_W-1:0]      grant_len,
  input logic [TOK_W-1:0]      cap_tok,
  input logic                  shcap_en
);

  localparam int CW = (LEN_W > DEF_W) ? LEN_W : DEF_W;

  logic [DEF_W-1:0] cur_def;
  assign cur_def = def_flat[grant_q*DEF_W +: DEF_W];

  // R8: a pending grant is held unchanged
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && !grant_accept |=> grant_valid && $stable(grant_q) && $stable(grant_lvl));

  // R8: one accept consumes one grant
  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && grant_accept |=> !grant_valid);

  // R10: reported level is a real level
  p_lvl_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> grant_lvl <= 3'd4);

  // R5: a fresh grant fits inside the queue's deficit
  p_fit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> CW'(grant_len) <= CW'(cur_def));

  // R4: strict-high grants under an enabled cap were covered by the cap bucket
  p_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) && grant_lvl == 3'd0 && $past(shcap_en) |->
      $past(cap_tok) >= TOK_W'(grant_len));

  // R6: empty queues lose their deficit
  for (genvar i = 0; i < NQ; i++) begin : g_clr
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !q_nonempty[i] |=> def_flat[i*DEF_W +: DEF_W] == '0);
  end

endmodule

bind egress_pdrr_sched egress_pdrr_sched_chk #(
  .NQ(NQ), .LEN_W(LEN_W), .TOK_W(TOK_W), .DEF_W(DEF_W)
) u_chk (
  .clk(clk), .rst_n(rst_sn), .grant_valid(grant_valid), .grant_accept(grant_accept),
  .grant_q(grant_q), .grant_lvl(grant_lvl), .q_nonempty(q_nonempty),
  .def_flat(def_flat), .grant_len(glen_q), .cap_tok(cap_tok), .shcap_en(shcap_en)
);

// File: tb/egress_pdrr_sched_bench.sv
module egress_pdrr_sched_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NQ = 8, LEN_W = 14, TOK_W = 20, DEF_W = 16;
  localparam int BIG = 60000;

  logic clk = 1'b0;
  logic rst_n;
  logic [NQ-1:0]       q_nonempty;
  logic [NQ*LEN_W-1:0] q_len;
  logic [NQ*2-1:0]     q_prio;
  logic [NQ*DEF_W-1:0] q_quantum;
  logic [NQ*TOK_W-1:0] q_cir_inc, q_cir_burst, q_eir_inc, q_eir_burst;
  logic                shcap_en;
  logic [TOK_W-1:0]    shcap_inc, shcap_burst;
  logic                grant_accept;
  logic                grant_valid;
  logic [2:0]          grant_q;
  logic [2:0]          grant_lvl;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  egress_pdrr_sched u_egress_pdrr_sched (
    .clk(clk), .rst_n(rst_n), .q_nonempty(q_nonempty), .q_len(q_len),
    .q_prio(q_prio), .q_quantum(q_quantum), .q_cir_inc(q_cir_inc),
    .q_cir_burst(q_cir_burst), .q_eir_inc(q_eir_inc), .q_eir_burst(q_eir_burst),
    .shcap_en(shcap_en), .shcap_inc(shcap_inc), .shcap_burst(shcap_burst),
    .grant_accept(grant_accept), .grant_valid(grant_valid),
    .grant_q(grant_q), .grant_lvl(grant_lvl)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int i, input bit ne, input int pr, input int len,
                     input int qt, input int ci, input int cb, input int ei, input int eb);
    q_nonempty[i]              = ne;
    q_prio[i*2 +: 2]           = 2'(pr);
    q_len[i*LEN_W +: LEN_W]    = LEN_W'(len);
    q_quantum[i*DEF_W +: DEF_W] = DEF_W'(qt);
    q_cir_inc[i*TOK_W +: TOK_W]   = TOK_W'(ci);
    q_cir_burst[i*TOK_W +: TOK_W] = TOK_W'(cb);
    q_eir_inc[i*TOK_W +: TOK_W]   = TOK_W'(ei);
    q_eir_burst[i*TOK_W +: TOK_W] = TOK_W'(eb);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    grant_accept = 1'b0;
    q_nonempty = '0; q_len = '0; q_prio = '0; q_quantum = '0;
    q_cir_inc = '0; q_cir_burst = '0; q_eir_inc = '0; q_eir_burst = '0;
    shcap_en = 1'b0; shcap_inc = '0; shcap_burst = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic take(output int gq, output int gl);
    gq = -1; gl = -1;
    for (int t = 0; t < 300; t++) begin
      if (grant_valid) begin
        gq = int'(grant_q); gl = int'(grant_lvl);
        grant_accept = 1'b1;
        @(negedge clk);
        grant_accept = 1'b0;
        break;
      end
      @(negedge clk);
    end
  endtask

  // R1, R9: no grant after reset until buckets receive their first refill
  task automatic t_reset();
    int gq, gl; bit quiet;
    do_reset();
    cfg(0, 1, 1, 100, 100, BIG, BIG, 0, 0);
    quiet = 1'b1;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (grant_valid) quiet = 1'b0;
    end
    check(quiet, "R1 idle after reset", int'(!quiet), 0);
    take(gq, gl);
    check(gq == 0, "R9 grant after first refill", gq, 0);
  endtask

  // R2, R10: lower level number wins every time
  task automatic t_strict();
    int gq, gl;
    do_reset();
    cfg(1, 1, 0, 100, 100, BIG, BIG, 0, 0);
    cfg(3, 1, 1, 100, 100, BIG, BIG, 0, 0);
    cfg(5, 1, 2, 100, 100, BIG, BIG, 0, 0);
    repeat (24) @(negedge clk);
    for (int n = 0; n < 3; n++) begin
      take(gq, gl);
      check(gq == 1, "R2 strict-high queue wins", gq, 1);
      check(gl == 0, "R10 level of strict-high win", gl, 0);
    end
  endtask

  // R7: round robin among equals on one level
  task automatic t_rr();
    int gq, gl;
    int exp_q[6] = '{2, 3, 6, 2, 3, 6};
    do_reset();
    cfg(2, 1, 1, 100, 100, BIG, BIG, 0, 0);
    cfg(3, 1, 1, 100, 100, BIG, BIG, 0, 0);
    cfg(6, 1, 1, 100, 100, BIG, BIG, 0, 0);
    repeat (24) @(negedge clk);
    for (int n = 0; n < 6; n++) begin
      take(gq, gl);
      check(gq == exp_q[n], "R7 round robin order", gq, exp_q[n]);
    end
  endtask

  // R5: long packet waits three rounds
  task automatic t_drr();
    int gq, gl;
    int exp_q[3] = '{0, 0, 1};
    do_reset();
    cfg(0, 1, 2, 100, 100, BIG, BIG, 0, 0);
    cfg(1, 1, 2, 300, 100, BIG, BIG, 0, 0);
    repeat (24) @(negedge clk);
    for (int n = 0; n < 3; n++) begin
      take(gq, gl);
      check(gq == exp_q[n], "R5 deficit gating", gq, exp_q[n]);
    end
  endtask

  // R3, R10: demotion to excess and ineligibility
  task automatic t_excess();
    int gq, gl; bit quiet;
    do_reset();
    cfg(0, 1, 0, 100, 100, 0, 0, BIG, BIG);
    cfg(4, 1, 2, 100, 100, BIG, BIG, 0, 0);
    cfg(7, 1, 0, 100, 100, 0, 0, 0, 0);
    repeat (24) @(negedge clk);
    take(gq, gl);
    check(gq == 4 && gl == 2, "R3 committed queue beats excess", gq, 4);
    q_nonempty[4] = 1'b0;
    take(gq, gl);
    check(gq == 0, "R3 excess queue served", gq, 0);
    check(gl == 3, "R10 excess-high level reported", gl, 3);
    q_nonempty[0] = 1'b0;
    quiet = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (grant_valid) quiet = 1'b0;
    end
    check(quiet, "R3 tokenless queue never granted", int'(!quiet), 0);
  endtask

  // R4: cap exhaustion lets a lower queue through
  task automatic t_cap();
    int gq, gl;
    do_reset();
    shcap_en = 1'b1; shcap_inc = TOK_W'(100); shcap_burst = TOK_W'(100);
    cfg(0, 1, 0, 100, 100, BIG, BIG, 0, 0);
    cfg(1, 1, 2, 100, 100, BIG, BIG, 0, 0);
    repeat (24) @(negedge clk);
    take(gq, gl);
    check(gq == 0 && gl == 0, "R4 strict-high within cap", gq, 0);
    take(gq, gl);
    check(gq == 1, "R4 lower queue served once cap spent", gq, 1);
  endtask

  // R6: stale deficit discarded after the queue empties
  task automatic t_clear();
    int gq, gl;
    do_reset();
    cfg(0, 1, 1, 100, 300, BIG, BIG, 0, 0);
    cfg(1, 0, 1, 100, 100, BIG, BIG, 0, 0);
    repeat (24) @(negedge clk);
    take(gq, gl);
    check(gq == 0, "R6 setup grant", gq, 0);
    q_nonempty[0] = 1'b0;
    repeat (3) @(negedge clk);
    q_len[0 +: LEN_W] = LEN_W'(200);
    q_nonempty[0] = 1'b1;
    q_nonempty[1] = 1'b1;
    take(gq, gl);
    check(gq == 1, "R6 cleared deficit forces new round", gq, 1);
  endtask

  // R9: bucket ceiling limits the burst
  task automatic t_sat();
    int cnt = 0;
    do_reset();
    cfg(0, 0, 1, 100, 4000, 100, 150, 0, 0);
    repeat (200) @(negedge clk);
    q_nonempty[0] = 1'b1;
    for (int c = 0; c < 12; c++) begin
      grant_accept = grant_valid;
      if (grant_valid) cnt++;
      @(negedge clk);
    end
    grant_accept = 1'b0;
    check(cnt >= 1 && cnt <= 2, "R9 burst ceiling", cnt, 1);
  endtask

  // R8: hold until accept, then drop
  task automatic t_hold();
    int gq0; bit held;
    do_reset();
    cfg(3, 1, 1, 100, 100, BIG, BIG, 0, 0);
    repeat (24) @(negedge clk);
    check(grant_valid == 1'b1, "R8 grant presented", int'(grant_valid), 1);
    gq0 = int'(grant_q);
    held = 1'b1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      if (!grant_valid || int'(grant_q) != gq0) held = 1'b0;
    end
    check(held && gq0 == 3, "R8 grant held without accept", gq0, 3);
    grant_accept = 1'b1;
    @(negedge clk);
    grant_accept = 1'b0;
    check(grant_valid == 1'b0, "R8 drop after accept", int'(grant_valid), 0);
  endtask

  initial begin
    t_reset();
    t_strict();
    t_rr();
    t_drr();
    t_excess();
    t_cap();
    t_clear();
    t_sat();
    t_hold();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule